// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a 32-bit control register bank that sits behind a simple request port and covers a 4 KB byte-addressed window. A lock flag blocks writes to the configuration registers. The flag starts set. Software clears it by writing a 16-bit magic key to a dedicated unlock register, and sets it again with a different key written to a dedicated lock register. A one-bit scratch register stays writable at all times.

Each word offset belongs to one access class: read-write, lock-exempt read-write, read-only, write-only or unmapped. The block responds one cycle after each request. Illegal accesses raise a one-cycle error flag in that response. Writing the reset-control register while the bank is unlocked stores the value, and if bit 0 of the data is set, the block also emits a one-cycle soft-reset request for the chip's reset logic.

The implemented set has the following registers:
- scratch at 0x000;
- lock key at 0x004;
- unlock key at 0x008;
- lock status at 0x00C;
- PLL control at 0x100;
- PLL status at 0x10C;
- clock control at 0x120;
- reset control at 0x200;
- boot mode at 0x25C;
- device ID at 0x530;
- a run of `PIN_WORDS` pin-configuration words starting at 0x700.

Top module: `skb_top`

## Requirements
- R1: After reset, the bank holds the following values:
  - lock status reads 1 (locked) and scratch reads 0;
  - 0x100 reads 0x0001A008, 0x10C reads 0x0000003F and 0x120 reads 0x1F000400;
  - 0x200 reads 0 and 0x25C reads 0x00000001;
  - every pin word (0x700 + 4*i, for i from 0 to PIN_WORDS-1) reads 0x00001601.
- R2: A write to 0x004 whose data bits [15:0] equal 0x767B sets the lock flag. Any other value leaves the flag unchanged. The upper 16 bits are ignored.
- R3: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears the lock flag. Any other value leaves the flag unchanged. The upper 16 bits are ignored.
- R4: While locked, a write to a read-write register (0x100, 0x120, 0x200 or a pin word) is discarded and raises the error flag.
- R5: The scratch register at 0x000 accepts writes whether the bank is locked or not. It keeps only data bit 0 and reads back as {31'b0, bit}. These writes raise no error.
- R6: A write to a read-only offset (0x00C, 0x10C, 0x25C, 0x530) or to an unmapped offset raises the error flag and changes no state, even while unlocked.
- R7: A read of a write-only offset (0x004, 0x008) or an unmapped offset returns 0 with the error flag. A read of any other implemented offset returns its word with no error.
- R8: rsp_valid, rsp_rdata, rsp_err and soft_reset_req are registered and relate to the request of the previous cycle. rsp_rdata is 0 for write responses and for idle cycles. Without a request, all four outputs are low or zero.
- R9: A write to 0x200 while unlocked stores all 32 bits. If data bit 0 is 1, soft_reset_req is high for exactly the following cycle. A locked write to 0x200, or an unlocked one with bit 0 clear, produces no request.
- R10: Address bits [1:0] are ignored, so any byte address inside a word reaches that word.
- R11: Offset 0x530 reads the ID_CODE parameter (default 0x00C0FFEE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_rdata | output | 32 | Read data of that response |
| rsp_err | output | 1 | Access error pulse for that response |
| soft_reset_req | output | 1 | One-cycle soft-reset request |

## Verification
Every result of this block is due exactly one clock edge after the request that causes it:
- the response word, the error flag and the soft-reset pulse all appear at that edge;
- a committed register or lock-flag change is seen by a read issued in the very next cycle.

The bench drives each request on a falling edge and lets the reference model compute the response due at the following rising edge. It then compares all four outputs one time unit after that edge. Idle cycles are compared the same way, so a pulse that lasts too long or comes a cycle late is caught.

// File: rtl/skb_pkg.sv
package skb_pkg;

  typedef enum logic [2:0] {
    AC_NONE = 3'd0,
    AC_RW   = 3'd1,
    AC_FREE = 3'd2,
    AC_RO   = 3'd3,
    AC_WO   = 3'd4
  } acc_e;

  // word indices (byte offset / 4)
  localparam int W_SCRATCH = 'h000;
  localparam int W_LOCK    = 'h001;
  localparam int W_UNLOCK  = 'h002;
  localparam int W_LSTAT   = 'h003;
  localparam int W_PLLCTL  = 'h040;
  localparam int W_PLLSTA  = 'h043;
  localparam int W_CLKCTL  = 'h048;
  localparam int W_RSTCTL  = 'h080;
  localparam int W_BOOT    = 'h097;
  localparam int W_IDCODE  = 'h14C;
  localparam int W_PIN0    = 'h1C0;

  localparam int NUM_FIXED = 3;   // slots 0..2 are PLL ctrl, clock ctrl, reset ctrl
  localparam int SLOT_RST  = 2;

  localparam logic [15:0] KEY_LOCK   = 16'h767B;
  localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

  localparam logic [31:0] PLLSTA_VAL = 32'h0000_003F;
  localparam logic [31:0] BOOT_VAL   = 32'h0000_0001;

  function automatic logic key_ok(input logic [31:0] data, input logic [15:0] key);
    return data[15:0] == key;
  endfunction

  function automatic int slot_word(input int slot);
    case (slot)
      0:       return W_PLLCTL;
      1:       return W_CLKCTL;
      2:       return W_RSTCTL;
      default: return W_PIN0 + slot - NUM_FIXED;
    endcase
  endfunction

  function automatic logic [31:0] slot_rst(input int slot);
    case (slot)
      0:       return 32'h0001_A008;
      1:       return 32'h1F00_0400;
      2:       return 32'h0000_0000;
      default: return 32'h0000_1601;
    endcase
  endfunction

endpackage

// File: rtl/skb_decode.sv
module skb_decode
  import skb_pkg::*;
#(
  parameter int WORD_W    = 10,
  parameter int PIN_WORDS = 8,
  localparam int NSLOT    = NUM_FIXED + PIN_WORDS
) (
  input  logic [WORD_W-1:0] word,
  output acc_e              cls,
  output logic [NSLOT-1:0]  slot_hit,
  output logic              hit_lock,
  output logic              hit_unlock
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_hit
    assign slot_hit[i] = (int'(word) == slot_word(i));
  end

  assign hit_lock   = (int'(word) == W_LOCK);
  assign hit_unlock = (int'(word) == W_UNLOCK);

  always_comb begin
    if (|slot_hit)                      cls = AC_RW;
    else if (int'(word) == W_SCRATCH)   cls = AC_FREE;
    else if (hit_lock || hit_unlock)    cls = AC_WO;
    else if (int'(word) == W_LSTAT  || int'(word) == W_PLLSTA ||
             int'(word) == W_BOOT   || int'(word) == W_IDCODE)
                                        cls = AC_RO;
    else                                cls = AC_NONE;
  end

endmodule

// File: rtl/skb_lock.sv
module skb_lock
  import skb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lock_try,
  input  logic        unlock_try,
  input  logic [31:0] wdata,
  output logic        locked,
  output logic        lock_evt,
  output logic        unlock_evt
);

  assign lock_evt   = lock_try   && key_ok(wdata, KEY_LOCK);
  assign unlock_evt = unlock_try && key_ok(wdata, KEY_UNLOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          locked <= 1'b1;
    else if (lock_evt)   locked <= 1'b1;
    else if (unlock_evt) locked <= 1'b0;
  end

  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_try && wdata[15:0] == 16'h767B) |=> locked); // R2
  AST_UNLOCK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_try && wdata[15:0] == 16'hDF0D) |=> !locked); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_try || unlock_try) |=> $stable(locked)); // R2

endmodule

// File: rtl/skb_regs.sv
module skb_regs
  import skb_pkg::*;
#(
  parameter int PIN_WORDS = 8,
  localparam int NSLOT    = NUM_FIXED + PIN_WORDS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       wr_en,
  input  logic                   scratch_we,
  input  logic [31:0]            wdata,
  output logic [NSLOT-1:0][31:0] slot_q,
  output logic                   scratch_q
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q[i] <= slot_rst(i);
      else if (wr_en[i]) slot_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          scratch_q <= 1'b0;
    else if (scratch_we) scratch_q <= wdata[0];
  end

  AST_SCRATCH_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    scratch_we |=> (scratch_q == $past(wdata[0]))); // R5
  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en)); // R10

endmodule

// File: rtl/skb_top.sv
module skb_top
  import skb_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          PIN_WORDS = 8,
  parameter logic [31:0] ID_CODE   = 32'h00C0_FFEE,
  localparam int         WORD_W    = ADDR_W - 2,
  localparam int         NSLOT     = NUM_FIXED + PIN_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              soft_reset_req
);

  logic [WORD_W-1:0]      word;
  acc_e                   cls;
  logic [NSLOT-1:0]       slot_hit;
  logic                   hit_lock, hit_unlock;
  logic                   locked, lock_evt, unlock_evt;
  logic [NSLOT-1:0][31:0] slot_q;
  logic                   scratch_q;

  // named internal events
  logic             wr, rd;
  logic             rw_commit, blocked_wr, bad_wr, bad_rd, err_evt, srst_evt;
  logic             scratch_we;
  logic [NSLOT-1:0] wr_en;
  logic [31:0]      rd_word;

  assign word = req_addr[ADDR_W-1:2];
  assign wr   = req_valid &&  req_write;
  assign rd   = req_valid && !req_write;

  skb_decode #(.WORD_W(WORD_W), .PIN_WORDS(PIN_WORDS)) u_dec (
    .word(word), .cls(cls), .slot_hit(slot_hit),
    .hit_lock(hit_lock), .hit_unlock(hit_unlock)
  );

  skb_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .lock_try(wr && hit_lock), .unlock_try(wr && hit_unlock),
    .wdata(req_wdata), .locked(locked),
    .lock_evt(lock_evt), .unlock_evt(unlock_evt)
  );

  assign rw_commit  = wr && cls == AC_RW && !locked;
  assign blocked_wr = wr && cls == AC_RW &&  locked;
  assign scratch_we = wr && cls == AC_FREE;
  assign bad_wr     = wr && (cls == AC_RO || cls == AC_NONE);
  assign bad_rd     = rd && (cls == AC_WO || cls == AC_NONE);
  assign err_evt    = bad_wr || bad_rd || blocked_wr;
  assign srst_evt   = rw_commit && slot_hit[SLOT_RST] && req_wdata[0];
  assign wr_en      = rw_commit ? slot_hit : '0;

  skb_regs #(.PIN_WORDS(PIN_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .scratch_we(scratch_we),
    .wdata(req_wdata), .slot_q(slot_q), .scratch_q(scratch_q)
  );

  always_comb begin
    rd_word = '0;
    case (cls)
      AC_RW: begin
        for (int i = 0; i < NSLOT; i++)
          if (slot_hit[i]) rd_word = rd_word | slot_q[i];
      end
      AC_FREE: rd_word = {31'b0, scratch_q};
      AC_RO: begin
        if (int'(word) == W_LSTAT)       rd_word = {31'b0, locked};
        else if (int'(word) == W_PLLSTA) rd_word = PLLSTA_VAL;
        else if (int'(word) == W_BOOT)   rd_word = BOOT_VAL;
        else                             rd_word = ID_CODE;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
      rsp_err        <= 1'b0;
      soft_reset_req <= 1'b0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_rdata      <= (rd && !bad_rd) ? rd_word : '0;
      rsp_err        <= err_evt;
      soft_reset_req <= srst_evt;
    end
  end

  AST_LOCKED_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_wr |=> $stable(slot_q)); // R4
  AST_BAD_WR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> ($stable(slot_q) && $stable(scratch_q) && $stable(locked))); // R6
  AST_SRST_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset_req |-> $past(!locked)); // R9
  AST_ERR_HAS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_err && !soft_reset_req)); // R8

endmodule

// File: tb/tb_skb_top.sv
module tb_skb_top;

  localparam int PINS = 8;
  localparam logic [31:0] IDV = 32'h00C0_FFEE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, soft_reset_req;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  skb_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .soft_reset_req(soft_reset_req)
  );

  // ---------------- reference model ----------------
  bit          m_locked;
  bit          m_scr;
  logic [31:0] m_reg [int];

  // 0 none, 1 rw, 2 free, 3 ro, 4 wo
  function automatic int kind(input int a);
    if (a == 'h100 || a == 'h120 || a == 'h200) return 1;
    if (a >= 'h700 && a < 'h700 + 4*PINS) return 1;
    if (a == 0) return 2;
    if (a == 'h00C || a == 'h10C || a == 'h25C || a == 'h530) return 3;
    if (a == 4 || a == 8) return 4;
    return 0;
  endfunction

  function automatic logic [31:0] peek(input int a);
    case (a)
      0:      return {31'b0, m_scr};
      'h00C:  return {31'b0, m_locked};
      'h10C:  return 32'h3F;
      'h25C:  return 32'h1;
      'h530:  return IDV;
      default: return m_reg[a];
    endcase
  endfunction

  task automatic model_reset();
    m_locked = 1; m_scr = 0;
    m_reg.delete();
    m_reg['h100] = 32'h0001A008;
    m_reg['h120] = 32'h1F000400;
    m_reg['h200] = 32'h0;
    for (int i = 0; i < PINS; i++) m_reg['h700 + 4*i] = 32'h1601;
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare just after the next rising edge
  task automatic step(input bit v, input bit w, input logic [11:0] addr,
                      input logic [31:0] d, input string tag);
    int a;
    int k;
    bit e_err, e_sr;
    logic [31:0] e_rd;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = addr; req_wdata = d;
    a = int'(addr) & 'hFFC;
    k = kind(a);
    e_err = 0; e_sr = 0; e_rd = 0;
    if (v && !w) begin
      if (k == 0 || k == 4) e_err = 1;
      else e_rd = peek(a);
    end else if (v && w) begin
      case (k)
        0, 3: e_err = 1;
        4: begin
          if (a == 4 && d[15:0] == 16'h767B) m_locked = 1;
          if (a == 8 && d[15:0] == 16'hDF0D) m_locked = 0;
        end
        2: m_scr = d[0];
        default: begin
          if (m_locked) e_err = 1;
          else begin
            m_reg[a] = d;
            if (a == 'h200 && d[0]) e_sr = 1;
          end
        end
      endcase
    end
    @(posedge clk); #1;
    check(rsp_valid == v, tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, v});
    check(rsp_err == e_err, tag, "rsp_err", {31'b0, rsp_err}, {31'b0, e_err});
    check(rsp_rdata == e_rd, tag, "rsp_rdata", rsp_rdata, e_rd);
    check(soft_reset_req == e_sr, tag, "soft_reset_req",
          {31'b0, soft_reset_req}, {31'b0, e_sr});
  endtask

  task automatic rd(input logic [11:0] a, input string tag); step(1, 0, a, 0, tag); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag); step(1, 1, a, d, tag); endtask
  task automatic idle(input string tag); step(0, 0, 0, 0, tag); endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8: idle after reset
    idle("R8"); idle("R8");
    // R1: reset values
    rd('h00C, "R1"); rd('h000, "R1"); rd('h100, "R1"); rd('h10C, "R1");
    rd('h120, "R1"); rd('h200, "R1"); rd('h25C, "R1");
    for (int i = 0; i < PINS; i++) rd(12'('h700 + 4*i), "R1");
    // R11
    rd('h530, "R11");
    // R4: locked writes discarded
    wr('h100, 32'hDEADBEEF, "R4"); rd('h100, "R4");
    wr('h704, 32'h12345678, "R4"); rd('h704, "R4");
    // R9: locked reset-control write gives no request
    wr('h200, 32'h1, "R9"); rd('h200, "R9");
    // R5: scratch while locked
    wr('h000, 32'hFFFFFFFE, "R5"); rd('h000, "R5");
    wr('h000, 32'h00000003, "R5"); rd('h000, "R5");
    // R3: wrong unlock keys ignored
    wr('h008, 32'h0000DF0E, "R3"); rd('h00C, "R3");
    wr('h008, 32'hDF0D0000, "R3"); rd('h00C, "R3");
    // R2: lock key at unlock address does nothing
    wr('h008, 32'h0000767B, "R2"); rd('h00C, "R2");
    // R3: good key with upper garbage
    wr('h008, 32'hABCDDF0D, "R3"); rd('h00C, "R3");
    // R5: scratch while unlocked
    wr('h000, 32'h0, "R5"); rd('h000, "R5");
    // R10: low address bits ignored
    wr('h103, 32'hCAFEF00D, "R10"); rd('h101, "R10"); rd('h100, "R10");
    wr('h122, 32'h0000A5A5, "R10"); rd('h123, "R10");
    for (int i = 0; i < PINS; i++) wr(12'('h700 + 4*i + (i % 4)), 32'h100 + i, "R10");
    for (int i = 0; i < PINS; i++) rd(12'('h700 + 4*i), "R10");
    // R6: read-only and unmapped writes while unlocked
    wr('h10C, 32'h0, "R6"); rd('h10C, "R6");
    wr('h25C, 32'hFF, "R6"); rd('h25C, "R6");
    wr('h530, 32'h0, "R6"); rd('h530, "R6");
    wr('h00C, 32'h1, "R6"); rd('h00C, "R6");
    wr('h800, 32'h5, "R6"); rd('h800, "R7");
    wr('h720 + 4*PINS, 32'h9, "R6"); rd('h100, "R6");
    // R7: write-only and unmapped reads
    rd('h004, "R7"); rd('h008, "R7"); rd('hFFC, "R7"); rd('h104, "R7");
    // R9: reset control
    wr('h200, 32'h00000005, "R9"); rd('h200, "R9");
    wr('h200, 32'hFFFF0004, "R9"); rd('h200, "R9");
    wr('h200, 32'h1, "R9"); wr('h200, 32'h3, "R9"); idle("R9");
    // R2: wrong lock key then right one
    wr('h004, 32'h0000767C, "R2"); rd('h00C, "R2");
    wr('h004, 32'h5555767B, "R2"); rd('h00C, "R2");
    wr('h200, 32'h1, "R9"); rd('h200, "R4");
    wr('h120, 32'h0, "R4"); rd('h120, "R4");
    // R8: mixed back-to-back then idle
    rd('h530, "R8"); wr('h000, 32'h1, "R8"); rd('h000, "R8"); idle("R8"); idle("R8");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule